// File: doc/BRIEF.md
# Upper Triangular Matrix Inverter

This block computes the inverse of a square upper-triangular fixed-point matrix. The working dimension is the current support size `s`, given with the start request. Only the top-left `s`-by-`s` triangle of the loaded matrix is used. Everything below the diagonal and every row or column at or beyond `s` is disregarded.

The inverse is built one column at a time in increasing column order. A single reusable column engine produces each column. It first forms, for every row above the diagonal, a multiply-accumulate over the already finished columns of the inverse. It then passes that sum through a slow bit-serial divider whose divisor is the diagonal element. The diagonal entry itself is the guarded reciprocal of the diagonal element.

A zero on the diagonal marks the matrix as singular. The column containing that zero is left at zero. The caller loads the matrix through a write port, pulses `start` with a size, waits for the one-cycle `done` pulse, and then reads the inverse through an addressed read port.

Top module: `uti_inverter`

## Requirements
- R1: Columns are produced in increasing order. Each entry (n,m) with n<m is -(sum over k from n to m-1 of Inv(n,k)*A(k,m)) / A(m,m). The sum is kept exact at 18 fractional bits, and the quotient is truncated toward zero to 9 fractional bits.
- R2: When A(m,m) is nonzero, the diagonal entry Inv(m,m) is 1/A(m,m), truncated toward zero.
- R3: When A(m,m) is zero, every entry of column m of the result stays zero.
- R4: `singular` is 1 at `done` if any diagonal element within the support was zero. It holds until the next accepted start, which clears it.
- R5: Only A(r,c) with r<=c<s affects the result. Result entries outside that triangle read as zero.
- R6: A start with size 0 or size above 11 is rejected. In the next cycle `done` pulses with `size_err`=1, `busy` stays 0, and the stored result is unchanged.
- R7: Each result entry saturates to the range -131072..131071 of the 18-bit signed format.
- R8: `done` is a one-cycle pulse. `busy` rises in the cycle after an accepted start and falls in the cycle `done` is high. A start while busy is ignored.
- R9: All values are 18-bit two's complement with 9 fractional bits. `rd_data` shows Inv(rd_row, rd_col) combinationally.
- R10: After reset, `busy`, `done`, `singular` and `size_err` are 0, and every result entry reads 0.
- R11: Each division takes one cycle per quotient bit (40 bits), so a 1-by-1 inversion completes no sooner than 40 cycles after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one element of the source matrix (ignored while busy) |
| ld_row | input | 4 | Row of the element written |
| ld_col | input | 4 | Column of the element written |
| ld_val | input | 18 | Element value, Q9 signed |
| start | input | 1 | Request an inversion |
| size | input | 4 | Support size for the request |
| busy | output | 1 | Inversion in progress |
| done | output | 1 | One-cycle completion pulse |
| singular | output | 1 | A zero diagonal element was met |
| size_err | output | 1 | Last request had an illegal size |
| rd_row | input | 4 | Result row to read |
| rd_col | input | 4 | Result column to read |
| rd_data | output | 18 | Result element, Q9 signed |

## Verification
The hardest case to reach from the ports is a zero pivot in the middle of a run. The next column must then accumulate through a zeroed column of the inverse, and the flag must persist until a later clean start clears it. The bench loads a 3-by-3 matrix whose middle diagonal element is zero and compares the whole result against an independent model. It then runs a clean matrix to see the flag drop.

A second case is a start request arriving while a run is in progress. The bench issues a 1-by-1 request partway through a 3-by-3 run and checks that the 3-by-3 result is intact. Saturation is reached with diagonal elements of one least-significant bit, whose reciprocal far exceeds the format.

// File: rtl/uti_pkg.sv
package uti_pkg;

  localparam int UTI_DATA_W = 18;
  localparam int UTI_FRAC_W = 9;
  localparam int UTI_MAX_N  = 11;

  typedef enum logic [1:0] {T_IDLE, T_GO, T_WAIT} top_st_t;

  typedef enum logic [2:0] {C_IDLE, C_MAC, C_DIVGO, C_DIVWAIT, C_DONE} col_st_t;

  // Turns a magnitude and a sign into a w-bit two's complement value,
  // clamped to the representable range (returned in the low w bits).
  function automatic logic [63:0] clamp_twos(input logic [63:0] mag,
                                             input logic neg,
                                             input int w);
    logic [63:0] lim;
    lim = 64'd1 << (w - 1);
    if (neg) return (mag > lim) ? (~lim + 64'd1) : (~mag + 64'd1);
    return (mag > lim - 64'd1) ? (lim - 64'd1) : mag;
  endfunction

endpackage

// File: rtl/uti_seq_div.sv
module uti_seq_div #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] work;
  logic [DEN_W-1:0] rem, den_q;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DEN_W:0]   trial, diff;
  logic             take;

  // restoring step: one quotient bit per cycle, dividend shifted MSB first
  assign trial = {rem, work[NUM_W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign take  = trial >= {1'b0, den_q};
  assign quo   = work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work  <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        work  <= num;
        rem   <= '0;
        den_q <= den;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        rem  <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        work <= {work[NUM_W-2:0], take};
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(NUM_W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assert_rem_below_den_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem < den_q));

  assert_div_multicycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !fin);

endmodule

// File: rtl/uti_col_unit.sv
module uti_col_unit
  import uti_pkg::*;
#(
  parameter int DATA_W = UTI_DATA_W,
  parameter int FRAC_W = UTI_FRAC_W,
  parameter int MAX_N  = UTI_MAX_N,
  localparam int IW    = $clog2(MAX_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [IW-1:0]            col,
  input  logic signed [DATA_W-1:0] diag,
  output logic [IW-1:0]            rd_row,
  output logic [IW-1:0]            rd_k,
  input  logic signed [DATA_W-1:0] rinv_nk,
  input  logic signed [DATA_W-1:0] r_km,
  output logic                     wr_en,
  output logic [IW-1:0]            wr_row,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     fin,
  output logic                     zero_diag
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + $clog2(MAX_N);
  localparam int ONE_SH = 2 * FRAC_W;

  col_st_t                  st;
  logic [IW-1:0]            col_q, n_q, k_q;
  logic signed [DATA_W-1:0] d_q;
  logic signed [ACC_W-1:0]  acc_q, acc_nx;
  logic signed [PROD_W-1:0] prod;
  logic                     zero_q, on_diag, res_neg, div_go, div_fin;
  logic [ACC_W-1:0]         div_num, div_quo;
  logic [DATA_W-1:0]        den_mag;
  logic [63:0]              clamped;

  assign prod    = rinv_nk * r_km;
  assign acc_nx  = acc_q + $signed({{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod});
  assign on_diag = (n_q == col_q);
  assign den_mag = d_q[DATA_W-1] ? $unsigned(-d_q) : $unsigned(d_q);
  assign div_num = on_diag ? (ACC_W'(1) << ONE_SH)
                           : (acc_q[ACC_W-1] ? $unsigned(-acc_q) : $unsigned(acc_q));
  // off-diagonal result is -acc/d: negative when acc and d share a sign
  assign res_neg = on_diag ? d_q[DATA_W-1] : (acc_q[ACC_W-1] == d_q[DATA_W-1]);
  assign div_go  = (st == C_DIVGO);
  assign clamped = clamp_twos(64'(div_quo), res_neg, DATA_W);

  assign rd_row    = n_q;
  assign rd_k      = k_q;
  assign wr_en     = (st == C_DIVWAIT) && div_fin;
  assign wr_row    = n_q;
  assign wr_data   = clamped[DATA_W-1:0];
  assign fin       = (st == C_DONE);
  assign zero_diag = zero_q;

  uti_seq_div #(.NUM_W(ACC_W), .DEN_W(DATA_W)) u_div (
    .clk (clk),
    .rst_n (rst_n),
    .go  (div_go),
    .num (div_num),
    .den (den_mag),
    .fin (div_fin),
    .quo (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= C_IDLE;
      col_q  <= '0;
      n_q    <= '0;
      k_q    <= '0;
      d_q    <= '0;
      acc_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      case (st)
        C_IDLE: if (go) begin
          col_q  <= col;
          d_q    <= diag;
          n_q    <= '0;
          k_q    <= '0;
          acc_q  <= '0;
          zero_q <= (diag == '0);
          if (diag == '0)      st <= C_DONE;
          else if (col == '0)  st <= C_DIVGO;
          else                 st <= C_MAC;
        end
        C_MAC: begin
          acc_q <= acc_nx;
          if (k_q == col_q - 1'b1) st <= C_DIVGO;
          else                     k_q <= k_q + 1'b1;
        end
        C_DIVGO: st <= C_DIVWAIT;
        C_DIVWAIT: if (div_fin) begin
          if (on_diag) st <= C_DONE;
          else begin
            n_q   <= n_q + 1'b1;
            k_q   <= n_q + 1'b1;
            acc_q <= '0;
            st    <= (n_q + 1'b1 == col_q) ? C_DIVGO : C_MAC;
          end
        end
        C_DONE: st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  assert_no_pivot_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_row == col_q) |-> (d_q != '0));

  assert_upper_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_row <= col_q));

endmodule

// File: rtl/uti_inverter.sv
module uti_inverter
  import uti_pkg::*;
#(
  parameter int DATA_W = UTI_DATA_W,
  parameter int FRAC_W = UTI_FRAC_W,
  parameter int MAX_N  = UTI_MAX_N,
  localparam int IW    = $clog2(MAX_N),
  localparam int SW    = $clog2(MAX_N + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [IW-1:0]            ld_row,
  input  logic [IW-1:0]            ld_col,
  input  logic [DATA_W-1:0]        ld_val,
  input  logic                     start,
  input  logic [SW-1:0]            size,
  output logic                     busy,
  output logic                     done,
  output logic                     singular,
  output logic                     size_err,
  input  logic [IW-1:0]            rd_row,
  input  logic [IW-1:0]            rd_col,
  output logic signed [DATA_W-1:0] rd_data
);
  logic signed [DATA_W-1:0] r_mem   [MAX_N][MAX_N];
  logic signed [DATA_W-1:0] inv_mem [MAX_N][MAX_N];

  top_st_t        st;
  logic [IW-1:0]  m_q;
  logic [SW-1:0]  sz_q;
  logic           size_ok, accept, last_col;

  logic                     cu_go, cu_wr_en, cu_fin, cu_zero;
  logic [IW-1:0]            cu_rd_row, cu_rd_k, cu_wr_row;
  logic [DATA_W-1:0]        cu_wr_data;
  logic signed [DATA_W-1:0] cu_rinv_nk, cu_r_km, cu_diag;

  assign size_ok  = (size != '0) && (int'(size) <= MAX_N);
  assign accept   = start && (st == T_IDLE) && size_ok;
  assign busy     = (st != T_IDLE);
  assign last_col = (SW'(m_q) + 1'b1 == sz_q);
  assign cu_go    = (st == T_GO);

  assign cu_diag    = r_mem[m_q][m_q];
  assign cu_r_km    = r_mem[cu_rd_k][m_q];
  assign cu_rinv_nk = inv_mem[cu_rd_row][cu_rd_k];

  assign rd_data = (int'(rd_row) < MAX_N && int'(rd_col) < MAX_N)
                   ? inv_mem[rd_row][rd_col] : '0;

  uti_col_unit #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .MAX_N(MAX_N)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (cu_go),
    .col       (m_q),
    .diag      (cu_diag),
    .rd_row    (cu_rd_row),
    .rd_k      (cu_rd_k),
    .rinv_nk   (cu_rinv_nk),
    .r_km      (cu_r_km),
    .wr_en     (cu_wr_en),
    .wr_row    (cu_wr_row),
    .wr_data   (cu_wr_data),
    .fin       (cu_fin),
    .zero_diag (cu_zero)
  );

  // source matrix: writable only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_N; i++)
        for (int j = 0; j < MAX_N; j++) r_mem[i][j] <= '0;
    end else if (ld_en && !busy && int'(ld_row) < MAX_N && int'(ld_col) < MAX_N) begin
      r_mem[ld_row][ld_col] <= ld_val;
    end
  end

  // result matrix: cleared on accepted start, filled column by column
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_N; i++)
        for (int j = 0; j < MAX_N; j++) inv_mem[i][j] <= '0;
    end else if (accept) begin
      for (int i = 0; i < MAX_N; i++)
        for (int j = 0; j < MAX_N; j++) inv_mem[i][j] <= '0;
    end else if (cu_wr_en) begin
      inv_mem[cu_wr_row][m_q] <= cu_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      m_q      <= '0;
      sz_q     <= '0;
      done     <= 1'b0;
      singular <= 1'b0;
      size_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          if (size_ok) begin
            sz_q     <= size;
            m_q      <= '0;
            singular <= 1'b0;
            size_err <= 1'b0;
            st       <= T_GO;
          end else begin
            size_err <= 1'b1;
            done     <= 1'b1;
          end
        end
        T_GO: st <= T_WAIT;
        T_WAIT: if (cu_fin) begin
          if (cu_zero) singular <= 1'b1;
          if (last_col) begin
            st   <= T_IDLE;
            done <= 1'b1;
          end else begin
            m_q <= m_q + 1'b1;
            st  <= T_GO;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_bad_size_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !size_ok) |=> (done && size_err && !busy));

  assert_singular_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && singular) |=> singular);

endmodule

// File: tb/sim_uti_inverter.sv
`timescale 1ns/1ps
module sim_uti_inverter;
  localparam int N  = 11;
  localparam int NC = 7;

  // table: size, 3x3 source (row-major, Q9), 3x3 expected result
  localparam int T_SZ [NC] = '{2, 3, 1, 1, 1, 1, 2};
  localparam int T_R [NC][9] = '{
    '{1024, 512, 0,    0, 2048, 0,    0, 0, 0},
    '{512, 1024, 1536, 0, 512, 2048,  0, 0, 512},
    '{-2048, 0, 0,     0, 0, 0,       0, 0, 0},
    '{1, 0, 0,         0, 0, 0,       0, 0, 0},
    '{-1, 0, 0,        0, 0, 0,       0, 0, 0},
    '{1536, 0, 0,      0, 0, 0,       0, 0, 0},
    '{1536, 512, 0,    0, 1536, 0,    0, 0, 0}};
  localparam int T_E [NC][9] = '{
    '{256, -64, 0,     0, 128, 0,     0, 0, 0},
    '{512, -1024, 2560, 0, 512, -2048, 0, 0, 512},
    '{-128, 0, 0,      0, 0, 0,       0, 0, 0},
    '{131071, 0, 0,    0, 0, 0,       0, 0, 0},
    '{-131072, 0, 0,   0, 0, 0,       0, 0, 0},
    '{170, 0, 0,       0, 0, 0,       0, 0, 0},
    '{170, -56, 0,     0, 170, 0,     0, 0, 0}};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ld_en = 1'b0, start = 1'b0;
  logic [3:0]  ld_row = '0, ld_col = '0, size = '0, rd_row = '0, rd_col = '0;
  logic [17:0] ld_val = '0;
  logic        busy, done, singular, size_err;
  logic signed [17:0] rd_data;

  int checks = 0, fails = 0;
  int     mr [N][N];
  longint mx [N][N];

  always #2.5 clk = ~clk;

  uti_inverter u0 (
    .clk (clk), .rst_n (rst_n), .ld_en (ld_en), .ld_row (ld_row), .ld_col (ld_col),
    .ld_val (ld_val), .start (start), .size (size), .busy (busy), .done (done),
    .singular (singular), .size_err (size_err), .rd_row (rd_row), .rd_col (rd_col),
    .rd_data (rd_data)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ld(input int r, input int c, input int v);
    @(negedge clk);
    ld_en = 1'b1; ld_row = 4'(r); ld_col = 4'(c); ld_val = 18'(v);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic rd(input int r, input int c, output longint v);
    @(negedge clk);
    rd_row = 4'(r); rd_col = 4'(c);
    #1 v = longint'(rd_data);
  endtask

  task automatic run(input int sz, output int cyc);
    @(negedge clk);
    start = 1'b1; size = 4'(sz);
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("R8 run timeout", 0, 1);
    else begin
      @(negedge clk);
      chk("R8 done lasts one cycle", done, 0);
    end
  endtask

  function automatic longint sat18(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  // independent model of the result using whole-number arithmetic
  task automatic model(input int s, output bit sing);
    sing = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) mx[r][c] = 0;
    for (int m = 0; m < s; m++) begin
      longint d;
      d = mr[m][m];
      if (d == 0) sing = 1'b1;
      else begin
        for (int n = 0; n < m; n++) begin
          longint acc;
          acc = 0;
          for (int k = n; k < m; k++) acc += mx[n][k] * mr[k][m];
          mx[n][m] = sat18(-acc / d);
        end
        mx[m][m] = sat18((longint'(1) << 18) / d);
      end
    end
  endtask

  task automatic load_model;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) ld(r, c, mr[r][c]);
  endtask

  task automatic compare_all(input string tag);
    longint v;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        rd(r, c, v);
        chk(tag, v, mx[r][c]);
      end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    #(5.0 * 190000);
    chk("R8 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    longint v;
    int cyc;
    bit sing;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 singular", singular, 0);
    chk("R10 size_err", size_err, 0);
    rd(0, 0, v);   chk("R10 result (0,0)", v, 0);
    rd(10, 10, v); chk("R10 result (10,10)", v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after release", busy, 0);

    // table walk: R1 R2 R7 R9 R11
    for (int t = 0; t < NC; t++) begin
      for (int i = 0; i < 9; i++) ld(i / 3, i % 3, T_R[t][i]);
      run(T_SZ[t], cyc);
      if (T_SZ[t] == 1) chk("R11 1x1 takes at least 40 cycles", (cyc >= 40) ? 1 : 0, 1);
      chk("R4 no singular on table case", singular, 0);
      for (int i = 0; i < 9; i++) begin
        rd(i / 3, i % 3, v);
        chk($sformatf("R1 R2 R7 R9 case %0d entry %0d", t, i), v, T_E[t][i]);
      end
    end

    // R6: illegal sizes are refused and leave the result untouched (case 6 result held)
    @(negedge clk); start = 1'b1; size = 4'd12;
    @(negedge clk); start = 1'b0;
    chk("R6 done on size 12", done, 1);
    chk("R6 size_err on size 12", size_err, 1);
    chk("R6 busy stays low", busy, 0);
    rd(0, 1, v); chk("R6 result unchanged", v, -56);
    @(negedge clk); start = 1'b1; size = 4'd0;
    @(negedge clk); start = 1'b0;
    chk("R6 done on size 0", done, 1);
    chk("R6 size_err on size 0", size_err, 1);
    rd(1, 1, v); chk("R6 result unchanged after size 0", v, 170);

    // R8: start while busy is ignored (3x3 matrix from case 1)
    for (int i = 0; i < 9; i++) ld(i / 3, i % 3, T_R[1][i]);
    @(negedge clk); start = 1'b1; size = 4'd3;
    @(negedge clk); start = 1'b0;
    chk("R8 busy after start", busy, 1);
    chk("R6 size_err cleared by accepted start", size_err, 0);
    repeat (5) @(negedge clk);
    start = 1'b1; size = 4'd1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    chk("R8 run completes", done, 1);
    @(negedge clk);
    chk("R8 busy low after done", busy, 0);
    rd(0, 2, v); chk("R8 second start ignored (0,2)", v, 2560);
    rd(2, 2, v); chk("R8 second start ignored (2,2)", v, 512);

    // R3 R4: zero pivot in the middle column
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) mr[r][c] = 0;
    mr[0][0] = 512; mr[0][1] = 1024; mr[0][2] = 1536;
    mr[1][1] = 0;   mr[1][2] = 2048; mr[2][2] = 1024;
    for (int i = 0; i < 9; i++) ld(i / 3, i % 3, mr[i / 3][i % 3]);
    model(3, sing);
    run(3, cyc);
    chk("R4 singular reported", singular, 1);
    chk("R4 model agrees singular", sing, 1);
    rd(0, 1, v); chk("R3 zero column (0,1)", v, 0);
    rd(1, 1, v); chk("R3 zero column (1,1)", v, 0);
    for (int i = 0; i < 9; i++) begin
      rd(i / 3, i % 3, v);
      chk("R3 singular case vs model", v, mx[i / 3][i % 3]);
    end
    // R4: clean run clears the flag; R5: garbage outside the triangle
    for (int i = 0; i < 9; i++) ld(i / 3, i % 3, T_R[1][i]);
    ld(1, 0, -5); ld(2, 0, 999); ld(2, 1, 4321);
    ld(0, 3, 5000); ld(3, 3, 77); ld(3, 0, -300);
    run(3, cyc);
    chk("R4 singular cleared", singular, 0);
    for (int i = 0; i < 9; i++) begin
      rd(i / 3, i % 3, v);
      chk("R5 outside entries ignored", v, T_E[1][i]);
    end
    rd(0, 3, v); chk("R5 result beyond size (0,3)", v, 0);
    rd(3, 3, v); chk("R5 result beyond size (3,3)", v, 0);

    // R1 R2 R7: full 11x11 against the model
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        if (r == c)     mr[r][c] = 384 + 128 * ((r * 5) % 4);
        else if (c > r) mr[r][c] = (((r * 7 + c * 3) % 9) - 4) * 48;
        else            mr[r][c] = 77 * (r - c);
      end
    load_model();
    model(N, sing);
    run(N, cyc);
    chk("R4 full matrix not singular", singular, 0);
    compare_all("R1 R2 R7 full 11x11");

    summary();
    $finish;
  end
endmodule